// File: doc/BRIEF.md
# Block Transfer and Compare Flag Generator

This combinational unit produces the status byte of an 8-bit processor after one step of a block-move or block-compare operation, together with a signal telling the sequencer whether a repeating form must run the step again. The sequencer supplies four inputs: the operation code, the accumulator, the memory byte that was just moved or read, and a single bit that is high when the 16-bit byte counter is still nonzero after this step's decrement. It also supplies the flag byte as it stood before the step.

Both outputs are pure functions of the present inputs. Bits 5 and 3 of the result come from intermediate sums and not from the visible result. A move takes them from the moved byte plus the accumulator. A compare takes them from the accumulator minus the byte, minus the half-borrow of that compare. Address stepping, the counter register, memory cycles and loop timing are the job of the surrounding sequencer.

Top module: `blk_xfer_flags`

## Requirements
- R1: Flag layout is S=bit7, Z=bit6, Y=bit5, H=bit4, X=bit3, P=bit2, N=bit1, C=bit0. The operation code `mode_op` is 00 move, 01 compare, 10 repeating move, 11 repeating compare. For both kinds of operation, P equals `cnt_nz`.
- R2: For a move, H and N are 0, and S, Z and C keep their values from `flags_in`.
- R3: For a move, with u = (`mem_byte` + `acc`) mod 256, Y equals u bit 1 and X equals u bit 3.
- R4: For a compare, with d = (`acc` - `mem_byte`) mod 256, S equals d bit 7, Z is 1 exactly when d is 0, and H is 1 exactly when the low nibble of `acc` is less than the low nibble of `mem_byte`.
- R5: For a compare, N is 1 and C keeps its value from `flags_in`.
- R6: For a compare, with t = (d - H) mod 256, X equals t bit 3 and Y equals t bit 1.
- R7: For a repeating move, `repeat_o` equals `cnt_nz`.
- R8: For a repeating compare, `repeat_o` is 1 exactly when `cnt_nz` is 1 and the new Z is 0.
- R9: For the single-step codes 00 and 01, `repeat_o` is 0 for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_op | input | 2 | Operation code: 00 move, 01 compare, 10 repeating move, 11 repeating compare |
| acc | input | 8 | Accumulator value |
| mem_byte | input | 8 | Byte moved or read from memory in this step |
| cnt_nz | input | 1 | High when the byte counter is nonzero after this step's decrement |
| flags_in | input | 8 | Flag byte before the step |
| flags_out | output | 8 | Flag byte after the step |
| repeat_o | output | 1 | High when a repeating form must run another step |

## Verification
No register sits between any input and `flags_out` or `repeat_o`, so every result is due in the same cycle as its stimulus. The bench applies each input set on the falling clock edge and reads both outputs 2 ns later, inside that same half period, before any new value arrives. It compares each reading against a reference model written from the requirements, and it checks named fields separately for the corner cases: sums that wrap, a half-borrow that changes t, and a compare match that ends the repeat.

// File: rtl/bxf_pkg.sv
package bxf_pkg;

    localparam int DW    = 8;
    localparam int NIB   = DW / 2;

    typedef logic [DW-1:0] byte_t;

    // Packed so that field order equals bit order 7..0 of the flag byte.
    typedef struct packed {
        logic s;
        logic z;
        logic y;
        logic h;
        logic x;
        logic p;
        logic n;
        logic c;
    } flag_s;

    typedef enum logic [1:0] {
        OP_MOVE     = 2'b00,
        OP_CMP      = 2'b01,
        OP_MOVE_RPT = 2'b10,
        OP_CMP_RPT  = 2'b11
    } blk_op_e;

    function automatic logic op_is_cmp(input blk_op_e op);
        return op[0];
    endfunction

    function automatic logic op_is_rpt(input blk_op_e op);
        return op[1];
    endfunction

    // Borrow out of the low nibble when subtracting b from a.
    function automatic logic nib_borrow(input byte_t a, input byte_t b);
        return a[NIB-1:0] < b[NIB-1:0];
    endfunction

endpackage

// File: rtl/bxf_move_unit.sv
module bxf_move_unit
    import bxf_pkg::*;
(
    input  byte_t acc,
    input  byte_t mem_byte,
    input  logic  cnt_nz,
    input  flag_s flags_in,
    output flag_s flags_mv
);

    byte_t side_sum;

    always_comb begin
        side_sum   = mem_byte + acc;
        flags_mv   = flags_in;
        flags_mv.h = 1'b0;
        flags_mv.n = 1'b0;
        flags_mv.p = cnt_nz;
        flags_mv.y = side_sum[1];
        flags_mv.x = side_sum[3];
    end

endmodule

// File: rtl/bxf_cmp_unit.sv
module bxf_cmp_unit
    import bxf_pkg::*;
(
    input  byte_t acc,
    input  byte_t mem_byte,
    input  logic  cnt_nz,
    input  flag_s flags_in,
    output flag_s flags_cp
);

    byte_t diff;
    byte_t adj;
    logic  half;

    always_comb begin
        diff       = acc - mem_byte;
        half       = nib_borrow(acc, mem_byte);
        adj        = diff - byte_t'(half);
        flags_cp.s = diff[DW-1];
        flags_cp.z = (diff == '0);
        flags_cp.h = half;
        flags_cp.y = adj[1];
        flags_cp.x = adj[3];
        flags_cp.p = cnt_nz;
        flags_cp.n = 1'b1;
        flags_cp.c = flags_in.c;
    end

endmodule

// File: rtl/bxf_repeat_unit.sv
module bxf_repeat_unit
    import bxf_pkg::*;
(
    input  blk_op_e op,
    input  logic    cnt_nz,
    input  logic    z_new,
    output logic    again
);

    always_comb begin
        unique case (op)
            OP_MOVE_RPT: again = cnt_nz;
            OP_CMP_RPT:  again = cnt_nz & ~z_new;
            default:     again = 1'b0;
        endcase
    end

endmodule

// File: rtl/blk_xfer_flags.sv
module blk_xfer_flags
    import bxf_pkg::*;
(
    input  logic [1:0] mode_op,
    input  logic [7:0] acc,
    input  logic [7:0] mem_byte,
    input  logic       cnt_nz,
    input  logic [7:0] flags_in,
    output logic [7:0] flags_out,
    output logic       repeat_o
);

    blk_op_e op;
    flag_s   f_old;
    flag_s   f_mv;
    flag_s   f_cp;
    flag_s   f_new;

    assign op    = blk_op_e'(mode_op);
    assign f_old = flag_s'(flags_in);

    bxf_move_unit u_move (
        .acc      (acc),
        .mem_byte (mem_byte),
        .cnt_nz   (cnt_nz),
        .flags_in (f_old),
        .flags_mv (f_mv)
    );

    bxf_cmp_unit u_cmp (
        .acc      (acc),
        .mem_byte (mem_byte),
        .cnt_nz   (cnt_nz),
        .flags_in (f_old),
        .flags_cp (f_cp)
    );

    assign f_new     = op_is_cmp(op) ? f_cp : f_mv;
    assign flags_out = f_new;

    bxf_repeat_unit u_rpt (
        .op     (op),
        .cnt_nz (cnt_nz),
        .z_new  (f_new.z),
        .again  (repeat_o)
    );

    // Cross-unit checks on the settled outputs.
    always_comb begin
        a_r1_pv_tracks_count: assert (f_new.p == cnt_nz);
        if (!op_is_cmp(op)) begin
            a_r2_move_keeps_szc: assert (f_new.s == f_old.s && f_new.z == f_old.z
                                         && f_new.c == f_old.c && !f_new.h && !f_new.n);
        end else begin
            a_r5_cmp_n_c: assert (f_new.n && f_new.c == f_old.c);
        end
        if (!op_is_rpt(op)) begin
            a_r9_single_no_repeat: assert (!repeat_o);
        end
        if (op == OP_CMP_RPT && f_new.z) begin
            a_r8_match_stops: assert (!repeat_o);
        end
        if (op == OP_MOVE_RPT) begin
            a_r7_move_repeat: assert (repeat_o == cnt_nz);
        end
        if (!cnt_nz) begin
            a_r7_r8_done_stops: assert (!repeat_o);
        end
    end

endmodule

// File: tb/test_blk_xfer_flags.sv
module test_blk_xfer_flags;

    logic       clk = 1'b0;
    logic [1:0] mode_op;
    logic [7:0] acc;
    logic [7:0] mem_byte;
    logic       cnt_nz;
    logic [7:0] flags_in;
    logic [7:0] flags_out;
    logic       repeat_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    blk_xfer_flags i_blk_xfer_flags (
        .mode_op   (mode_op),
        .acc       (acc),
        .mem_byte  (mem_byte),
        .cnt_nz    (cnt_nz),
        .flags_in  (flags_in),
        .flags_out (flags_out),
        .repeat_o  (repeat_o)
    );

    // Reference model written from the requirements.
    function automatic logic [7:0] ref_flags(input logic [1:0] op, input logic [7:0] a,
                                             input logic [7:0] m, input logic nz,
                                             input logic [7:0] fo);
        logic [7:0] r, u, d, t;
        logic hb;
        r = fo;
        if (op[0] == 1'b0) begin
            u    = 8'(a + m);
            r[4] = 1'b0; r[1] = 1'b0;
            r[5] = u[1]; r[3] = u[3];
        end else begin
            d    = 8'(a - m);
            hb   = (a & 8'h0F) < (m & 8'h0F);
            t    = 8'(d - {7'd0, hb});
            r[7] = d[7]; r[6] = (d == 8'd0); r[4] = hb;
            r[5] = t[1]; r[3] = t[3]; r[1] = 1'b1;
        end
        r[2] = nz;
        return r;
    endfunction

    function automatic logic ref_rep(input logic [1:0] op, input logic nz, input logic znew);
        if (op == 2'b10) return nz;
        if (op == 2'b11) return nz & ~znew;
        return 1'b0;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic [7:0] a, input logic [7:0] m,
                         input logic nz, input logic [7:0] f);
        @(negedge clk);
        mode_op = op; acc = a; mem_byte = m; cnt_nz = nz; flags_in = f;
        #2;
    endtask

    task automatic t_idle;
        apply(2'b00, 8'h00, 8'h00, 1'b0, 8'h00);
        chk("R2 idle flags", flags_out, 8'h00);
        chk("R9 idle repeat", {7'd0, repeat_o}, 8'h00);
    endtask

    task automatic t_move_basic;
        apply(2'b10, 8'h10, 8'h22, 1'b1, 8'hFF);
        chk("R2 R3 move flags", flags_out, 8'hE5);
        chk("R7 move repeat nz", {7'd0, repeat_o}, 8'h01);
        apply(2'b10, 8'h10, 8'h22, 1'b0, 8'h00);
        chk("R1 move pv low", {7'd0, flags_out[2]}, 8'h00);
        chk("R7 move repeat end", {7'd0, repeat_o}, 8'h00);
    endtask

    task automatic t_move_wrap;
        // 0xF6 + 0x14 = 0x10A -> 0x0A: bit1=1, bit3=1
        apply(2'b00, 8'hF6, 8'h14, 1'b1, 8'h00);
        chk("R3 move wrap Y", {7'd0, flags_out[5]}, 8'h01);
        chk("R3 move wrap X", {7'd0, flags_out[3]}, 8'h01);
        chk("R9 single move no repeat", {7'd0, repeat_o}, 8'h00);
    endtask

    task automatic t_cmp_match;
        apply(2'b11, 8'h20, 8'h20, 1'b1, 8'h01);
        chk("R4 R5 cmp match flags", flags_out, 8'h47);
        chk("R8 match stops repeat", {7'd0, repeat_o}, 8'h00);
        apply(2'b11, 8'h21, 8'h20, 1'b1, 8'h00);
        chk("R8 mismatch repeats", {7'd0, repeat_o}, 8'h01);
    endtask

    task automatic t_cmp_halfborrow;
        // d=0x0F, H=1, t=0x0E -> Y=1, X=1
        apply(2'b01, 8'h10, 8'h01, 1'b0, 8'h00);
        chk("R6 cmp half-borrow flags", flags_out, 8'h3A);
        chk("R4 cmp H", {7'd0, flags_out[4]}, 8'h01);
        chk("R9 single cmp no repeat", {7'd0, repeat_o}, 8'h00);
        // d=0x80 negative, t wraps nothing; S=1
        apply(2'b01, 8'h00, 8'h80, 1'b1, 8'h01);
        chk("R4 cmp sign", {7'd0, flags_out[7]}, 8'h01);
        chk("R5 cmp keeps C", {7'd0, flags_out[0]}, 8'h01);
    endtask

    task automatic t_cmp_t_wrap;
        // d=0x00 impossible with H=1; use a=0x00,m=0x01: d=0xFF,H=1,t=0xFE
        apply(2'b01, 8'h00, 8'h01, 1'b1, 8'h00);
        chk("R6 cmp t wrap", flags_out, ref_flags(2'b01, 8'h00, 8'h01, 1'b1, 8'h00));
    endtask

    task automatic t_sweep;
        for (int op = 0; op < 4; op++) begin
            for (int a = 0; a < 256; a += 23) begin
                for (int m = 0; m < 256; m += 29) begin
                    logic [7:0] e;
                    logic [7:0] f;
                    logic       nz;
                    f  = 8'(a ^ (m << 1));
                    nz = ((a + m) & 1) != 0;
                    apply(2'(op), 8'(a), 8'(m), nz, f);
                    e = ref_flags(2'(op), 8'(a), 8'(m), nz, f);
                    chk("R1 R3 R6 sweep flags", flags_out, e);
                    chk("R7 R8 R9 sweep repeat", {7'd0, repeat_o},
                        {7'd0, ref_rep(2'(op), nz, e[6])});
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        mode_op = 2'b00; acc = 8'h00; mem_byte = 8'h00; cnt_nz = 1'b0; flags_in = 8'h00;
        repeat (2) @(posedge clk);
        t_idle();
        t_move_basic();
        t_move_wrap();
        t_cmp_match();
        t_cmp_halfborrow();
        t_cmp_t_wrap();
        t_sweep();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule